// File: doc/BRIEF.md
# Debug bus access comparator bank

A bank of three bus-watch comparators for an on-chip debug unit. Each comparator holds a programmed address and a set of qualifier flags. It watches the CPU system bus, which carries an address, a direction, an access size and an opcode-fetch marker, and it raises a sticky match flag for a debug state sequencer. Match bit 0 belongs to comparator A, bit 1 to comparator B and bit 2 to comparator C. Comparators A and B can also qualify on access size. Comparator C qualifies only on address and direction.

Each comparator runs in one of two modes. In forced mode the match is raised as soon as a qualifying access appears on the bus, including an opcode fetch that may be far ahead of execution. In tagged mode, opcode fetches from the programmed address are queued as fetch identifiers. The match is raised only when the execute-stage strobe reports the identifier at the head of that queue. A pipeline flush discards all queued identifiers.

Top module: `dbg_cmp_bank`

## Requirements
- R1: In forced mode (tag=0) an enabled comparator sets its match one clock after a valid bus access whose address equals its programmed address exactly. Any other address gives no match.
- R2: A word access (bus_word_i=1) at address n-1 does not match a comparator programmed with n, even though it covers byte n.
- R3: Direction qualifier, with bus_rd_i=1 meaning read: rwe=0 matches both directions, rwe=1 with rw=0 matches only writes, and rwe=1 with rw=1 matches only reads.
- R4: On comparators A and B, sze=1 requires the access size to equal sz (1 = word, 0 = byte). sze=0 matches either size.
- R5: Comparator C ignores sze and sz. An access of either size matches.
- R6: In forced mode an opcode fetch (bus_fetch_i=1) from the programmed address matches at fetch time.
- R7: In tagged mode rwe, rw, sze and sz are ignored. No match is raised at fetch time. The match is set one clock after exec_i arrives with exec_id_i equal to the oldest pending fetch identifier.
- R8: A match stays set until it is cleared or its comparator is disabled, whatever the later bus activity.
- R9: clr_i[k] clears match bit k on the next clock, and it takes priority over a match set in the same cycle.
- R10: Match bits 0, 1 and 2 belong to comparators A, B and C, in that order.
- R11: A disabled comparator (en=0) never sets its match, and disabling it clears both its match and its pending tags.
- R12: Each comparator holds up to DEPTH (4) pending fetch identifiers and drops further fetches while full. An execute strobe with an identifier other than the oldest one releases nothing. flush_i discards all pending identifiers.
- R13: During and right after reset all match outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_valid_i | input | 1 | Bus access present this cycle |
| bus_addr_i | input | AW | Bus access address |
| bus_rd_i | input | 1 | 1 = read, 0 = write |
| bus_word_i | input | 1 | 1 = word, 0 = byte |
| bus_fetch_i | input | 1 | Access is an opcode fetch |
| fetch_id_i | input | IDW | Identifier given to this fetch |
| exec_i | input | 1 | Execute-stage strobe |
| exec_id_i | input | IDW | Identifier of the executing instruction |
| flush_i | input | 1 | Pipeline flush, drops all pending tags |
| clr_i | input | NCMP | Per-comparator match clear |
| cfg_en_i | input | NCMP | Comparator enable |
| cfg_tag_i | input | NCMP | 1 = tagged mode, 0 = forced mode |
| cfg_rwe_i | input | NCMP | Direction qualifier enable |
| cfg_rw_i | input | NCMP | Direction to match, 1 = read |
| cfg_sze_i | input | NCMP | Size qualifier enable (A and B only) |
| cfg_sz_i | input | NCMP | Size to match, 1 = word |
| cfg_addr_i | input | NCMP*AW | Programmed addresses, comparator k in bits k*AW upward |
| match_o | output | NCMP | Sticky match flags |

## Verification
Every result is due exactly one clock after its stimulus. A forced match, a tagged release on the execute strobe, a clear and the clear caused by disabling a comparator each pass through one register stage. Queued tags only change state and show up on the port at a later execute strobe. The driver applies each cycle's stimulus on the falling edge and queues the full expected three-bit match vector. The monitor pops one entry per cycle, one time unit after the next rising edge, so each comparison lands on the cycle the result is due. Sticky, clear-priority and ignored-qualifier cases are checked with that vector, so any side effect on a neighbouring comparator also shows up.

// File: rtl/dbg_cmp_pkg.sv
package dbg_cmp_pkg;
  typedef struct packed {
    logic en;
    logic tag;
    logic rwe;
    logic rw;
    logic sze;
    logic sz;
  } cmp_cfg_t;
endpackage

// File: rtl/dbg_cmp_qual.sv
module dbg_cmp_qual #(
  parameter int AW       = 16,
  parameter bit HAS_SIZE = 1'b1
) (
  input  dbg_cmp_pkg::cmp_cfg_t cfg_i,
  input  logic [AW-1:0]         cmp_addr_i,
  input  logic                  valid_i,
  input  logic [AW-1:0]         addr_i,
  input  logic                  rd_i,
  input  logic                  word_i,
  input  logic                  fetch_i,
  output logic                  forced_hit_o,
  output logic                  fetch_hit_o
);
  logic addr_eq, dir_ok, size_ok;

  // exact, byte-granular compare: a covering word access never hits
  assign addr_eq = valid_i && (addr_i == cmp_addr_i);
  assign dir_ok  = !cfg_i.rwe || (cfg_i.rw == rd_i);

  generate
    if (HAS_SIZE) begin : g_size
      assign size_ok = !cfg_i.sze || (cfg_i.sz == word_i);
    end else begin : g_nosize
      assign size_ok = 1'b1;
    end
  endgenerate

  assign forced_hit_o = addr_eq && dir_ok && size_ok;
  assign fetch_hit_o  = addr_eq && fetch_i;
endmodule

// File: rtl/dbg_cmp_tagq.sv
module dbg_cmp_tagq #(
  parameter int IDW   = 3,
  parameter int DEPTH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           flush_i,
  input  logic           push_i,
  input  logic [IDW-1:0] push_id_i,
  input  logic           exec_i,
  input  logic [IDW-1:0] exec_id_i,
  output logic           release_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [IDW-1:0] mem_q [DEPTH];
  logic [PW-1:0]  wr_q, rd_q;
  logic [CW-1:0]  cnt_q;
  logic           do_push;

  assign release_o = exec_i && (cnt_q != '0) && (mem_q[rd_q] == exec_id_i);
  assign do_push   = push_i && (cnt_q != FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (release_o) rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      if (do_push && !release_o) cnt_q <= cnt_q + 1'b1;
      else if (!do_push && release_o) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_q] <= push_id_i;
  end
endmodule

// File: rtl/dbg_cmp_chan.sv
module dbg_cmp_chan #(
  parameter int AW       = 16,
  parameter int IDW      = 3,
  parameter int DEPTH    = 4,
  parameter bit HAS_SIZE = 1'b1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  dbg_cmp_pkg::cmp_cfg_t cfg_i,
  input  logic [AW-1:0]         cmp_addr_i,
  input  logic                  valid_i,
  input  logic [AW-1:0]         addr_i,
  input  logic                  rd_i,
  input  logic                  word_i,
  input  logic                  fetch_i,
  input  logic [IDW-1:0]        fetch_id_i,
  input  logic                  exec_i,
  input  logic [IDW-1:0]        exec_id_i,
  input  logic                  flush_i,
  input  logic                  clr_i,
  output logic                  match_o
);
  logic forced_hit, fetch_hit, released, set, match_q;

  dbg_cmp_qual #(.AW(AW), .HAS_SIZE(HAS_SIZE)) u_qual (
    .cfg_i        (cfg_i),
    .cmp_addr_i   (cmp_addr_i),
    .valid_i      (valid_i),
    .addr_i       (addr_i),
    .rd_i         (rd_i),
    .word_i       (word_i),
    .fetch_i      (fetch_i),
    .forced_hit_o (forced_hit),
    .fetch_hit_o  (fetch_hit)
  );

  dbg_cmp_tagq #(.IDW(IDW), .DEPTH(DEPTH)) u_tagq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i || !cfg_i.en || !cfg_i.tag),
    .push_i    (cfg_i.en && cfg_i.tag && fetch_hit),
    .push_id_i (fetch_id_i),
    .exec_i    (exec_i),
    .exec_id_i (exec_id_i),
    .release_o (released)
  );

  assign set = cfg_i.en && (cfg_i.tag ? released : forced_hit);

  // sticky: the condition is not rechecked once set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   match_q <= 1'b0;
    else if (!cfg_i.en || clr_i)   match_q <= 1'b0;
    else if (set)                  match_q <= 1'b1;
  end

  assign match_o = match_q;
endmodule

// File: rtl/dbg_cmp_bank.sv
module dbg_cmp_bank #(
  parameter int              AW        = 16,
  parameter int              IDW       = 3,
  parameter int              DEPTH     = 4,
  parameter int              NCMP      = 3,
  parameter logic [NCMP-1:0] SIZE_MASK = 3'b011
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic              bus_rd_i,
  input  logic              bus_word_i,
  input  logic              bus_fetch_i,
  input  logic [IDW-1:0]    fetch_id_i,
  input  logic              exec_i,
  input  logic [IDW-1:0]    exec_id_i,
  input  logic              flush_i,
  input  logic [NCMP-1:0]   clr_i,
  input  logic [NCMP-1:0]   cfg_en_i,
  input  logic [NCMP-1:0]   cfg_tag_i,
  input  logic [NCMP-1:0]   cfg_rwe_i,
  input  logic [NCMP-1:0]   cfg_rw_i,
  input  logic [NCMP-1:0]   cfg_sze_i,
  input  logic [NCMP-1:0]   cfg_sz_i,
  input  logic [NCMP*AW-1:0] cfg_addr_i,
  output logic [NCMP-1:0]   match_o
);
  import dbg_cmp_pkg::*;

  for (genvar k = 0; k < NCMP; k++) begin : g_cmp
    cmp_cfg_t cfg;
    assign cfg = '{en: cfg_en_i[k], tag: cfg_tag_i[k], rwe: cfg_rwe_i[k],
                   rw: cfg_rw_i[k], sze: cfg_sze_i[k], sz: cfg_sz_i[k]};

    dbg_cmp_chan #(.AW(AW), .IDW(IDW), .DEPTH(DEPTH), .HAS_SIZE(SIZE_MASK[k])) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_i      (cfg),
      .cmp_addr_i (cfg_addr_i[k*AW +: AW]),
      .valid_i    (bus_valid_i),
      .addr_i     (bus_addr_i),
      .rd_i       (bus_rd_i),
      .word_i     (bus_word_i),
      .fetch_i    (bus_fetch_i),
      .fetch_id_i (fetch_id_i),
      .exec_i     (exec_i),
      .exec_id_i  (exec_id_i),
      .flush_i    (flush_i),
      .clr_i      (clr_i[k]),
      .match_o    (match_o[k])
    );
  end
endmodule

// File: rtl/dbg_cmp_bank_chk.sv
module dbg_cmp_bank_chk #(
  parameter int AW   = 16,
  parameter int NCMP = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bus_valid_i,
  input logic [AW-1:0]      bus_addr_i,
  input logic               exec_i,
  input logic [NCMP-1:0]    clr_i,
  input logic [NCMP-1:0]    cfg_en_i,
  input logic [NCMP-1:0]    cfg_tag_i,
  input logic [NCMP*AW-1:0] cfg_addr_i,
  input logic [NCMP-1:0]    match_o
);
  for (genvar k = 0; k < NCMP; k++) begin : g_chk
    a_r11_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_en_i[k] |=> !match_o[k]);

    a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (match_o[k] && cfg_en_i[k] && !clr_i[k]) |=> match_o[k]);

    a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[k] |=> !match_o[k]);

    a_r7_tag_on_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(match_o[k]) && $past(cfg_tag_i[k])) |-> $past(exec_i));

    a_r1_forced_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(match_o[k]) && !$past(cfg_tag_i[k])) |->
        ($past(bus_valid_i) && ($past(bus_addr_i) == $past(cfg_addr_i[k*AW +: AW]))));
  end
endmodule

bind dbg_cmp_bank dbg_cmp_bank_chk #(.AW(AW), .NCMP(NCMP)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_valid_i (bus_valid_i),
  .bus_addr_i  (bus_addr_i),
  .exec_i      (exec_i),
  .clr_i       (clr_i),
  .cfg_en_i    (cfg_en_i),
  .cfg_tag_i   (cfg_tag_i),
  .cfg_addr_i  (cfg_addr_i),
  .match_o     (match_o)
);

// File: tb/dbg_cmp_bank_test.sv
`timescale 1ns/1ps
module dbg_cmp_bank_test;
  localparam int AW = 16, IDW = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic bus_valid = 0, bus_rd = 0, bus_word = 0, bus_fetch = 0, exec = 0, flush = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [IDW-1:0] fetch_id = '0, exec_id = '0;
  logic [2:0] clr = '0, en = 3'b111, tag = '0, rwe = '0, rw = '0, sze = '0, sz = '0;
  logic [3*AW-1:0] addrs = {16'h3000, 16'h2000, 16'h1000};
  logic [2:0] match;

  int checks = 0, errors = 0;
  logic [2:0] exp_q[$];
  string req_q[$];

  always #2 clk = ~clk;

  dbg_cmp_bank uut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_valid_i(bus_valid), .bus_addr_i(bus_addr),
    .bus_rd_i(bus_rd), .bus_word_i(bus_word), .bus_fetch_i(bus_fetch),
    .fetch_id_i(fetch_id), .exec_i(exec), .exec_id_i(exec_id), .flush_i(flush),
    .clr_i(clr), .cfg_en_i(en), .cfg_tag_i(tag), .cfg_rwe_i(rwe), .cfg_rw_i(rw),
    .cfg_sze_i(sze), .cfg_sz_i(sz), .cfg_addr_i(addrs), .match_o(match)
  );

  task automatic check(input logic [2:0] act, input logic [2:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: match=%b expected=%b", req, act, exp);
    end
  endtask

  // monitor: one result per cycle, due one clock after its stimulus
  initial forever begin
    @(posedge clk); #1;
    if (exp_q.size() != 0) check(match, exp_q.pop_front(), req_q.pop_front());
  end

  task automatic acc(input logic [AW-1:0] a, input logic rd, input logic wd,
                     input logic f = 1'b0, input logic [IDW-1:0] id = '0);
    bus_valid = 1; bus_addr = a; bus_rd = rd; bus_word = wd; bus_fetch = f; fetch_id = id;
  endtask

  task automatic step(input logic [2:0] exp, input string req);
    exp_q.push_back(exp); req_q.push_back(req);
    @(negedge clk);
    bus_valid = 0; bus_fetch = 0; exec = 0; flush = 0; clr = '0;
  endtask

  task automatic ex(input logic [IDW-1:0] id);
    exec = 1; exec_id = id;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(match, 3'b000, "R13 in reset");
    rst_ni = 1;
    step(3'b000, "R13 after reset");
    acc(16'h1000, 1, 0); step(3'b001, "R1 exact hit A / R10");
    step(3'b001, "R8 sticky idle");
    acc(16'h1234, 0, 1); step(3'b001, "R8 sticky other access");
    clr = 3'b001; step(3'b000, "R9 clear");
    acc(16'h2000, 1, 0); step(3'b010, "R10 B bit1");
    acc(16'h3000, 0, 0); step(3'b110, "R10 C bit2");
    clr = 3'b111; step(3'b000, "R9 clear all");
    acc(16'h0FFF, 1, 1); step(3'b000, "R2 word n-1 A");
    acc(16'h2FFF, 0, 1); step(3'b000, "R2 word n-1 C");
    acc(16'h1001, 1, 0); step(3'b000, "R1 adjacent address");
    acc(16'h1000, 1, 0); clr = 3'b001; step(3'b000, "R9 clear beats set");
    rwe = 3'b001; rw = 3'b000;
    acc(16'h1000, 1, 0); step(3'b000, "R3 write-only rejects read");
    acc(16'h1000, 0, 0); step(3'b001, "R3 write-only takes write");
    clr = 3'b001; step(3'b000, "R9 clear");
    rw = 3'b001;
    acc(16'h1000, 0, 0); step(3'b000, "R3 read-only rejects write");
    acc(16'h1000, 1, 0); step(3'b001, "R3 read-only takes read");
    clr = 3'b001; step(3'b000, "R9 clear");
    rwe = '0; rw = '0;
    sze = 3'b110; sz = 3'b110;
    acc(16'h2000, 1, 0); step(3'b000, "R4 B size word rejects byte");
    acc(16'h2000, 1, 1); step(3'b010, "R4 B size word takes word");
    acc(16'h3000, 1, 0); step(3'b110, "R5 C ignores size");
    clr = 3'b110; step(3'b000, "R9 clear");
    sze = '0; sz = '0;
    en = 3'b101;
    acc(16'h2000, 1, 1); step(3'b000, "R11 disabled B");
    en = 3'b111;
    acc(16'h1000, 1, 0, 1, 3'd2); step(3'b001, "R6 forced hit at fetch");
    clr = 3'b001; step(3'b000, "R9 clear");
    // tagged mode on A; write-only direction must be ignored
    tag = 3'b001; rwe = 3'b001; rw = 3'b000;
    acc(16'h1000, 1, 0, 1, 3'd2); step(3'b000, "R7 no match at fetch");
    step(3'b000, "R7 idle before exec");
    ex(3'd2); step(3'b001, "R7 match on exec");
    clr = 3'b001; step(3'b000, "R9 clear");
    acc(16'h1000, 1, 0, 0, 3'd0); step(3'b000, "R7 data read not queued");
    ex(3'd0); step(3'b000, "R7 exec with empty queue");
    acc(16'h1000, 1, 0, 1, 3'd1); step(3'b000, "R12 queue id1");
    acc(16'h1000, 1, 0, 1, 3'd5); step(3'b000, "R12 queue id5");
    ex(3'd5); step(3'b000, "R12 non-head exec ignored");
    ex(3'd1); step(3'b001, "R12 head released");
    clr = 3'b001; step(3'b000, "R9 clear");
    ex(3'd5); step(3'b001, "R12 second released in order");
    clr = 3'b001; step(3'b000, "R9 clear");
    acc(16'h1000, 1, 0, 1, 3'd3); step(3'b000, "R12 queue id3");
    flush = 1; step(3'b000, "R12 flush");
    ex(3'd3); step(3'b000, "R12 flushed tag not released");
    for (int i = 0; i < 5; i++) begin
      acc(16'h1000, 1, 0, 1, 3'(i)); step(3'b000, "R12 fill queue");
    end
    for (int i = 0; i < 4; i++) begin
      ex(3'(i)); step(3'b001, "R12 queued tag released");
      clr = 3'b001; step(3'b000, "R9 clear");
    end
    ex(3'd4); step(3'b000, "R12 fetch beyond depth dropped");
    acc(16'h1000, 1, 0, 1, 3'd6); step(3'b000, "R11 queue id6");
    en = 3'b110; step(3'b000, "R11 disable A");
    en = 3'b111; ex(3'd6); step(3'b000, "R11 disable dropped tags");
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: cycles=5000 expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule